// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block is the receive side of a serial port running in synchronous slave mode. A remote master drives the shift clock and serial data. The block brings both lines into the system clock domain through a two-flop synchroniser. It samples the data line on each falling edge of the remote clock, least significant bit first, and builds an 8-bit or 9-bit word. When the last bit arrives, the word moves into a holding register. A receive-complete flag is then raised. If the receive interrupt is enabled, an interrupt level and a one-cycle wake request are also produced.

Configuration arrives as plain level inputs: port enable, synchronous select, clock-source select, 9-bit enable, continuous-receive enable and the single-receive enable. The single-receive enable is ignored in slave mode. Software reads the ninth bit and the overrun status first, then pulses the read strobe for the data byte. If a word completes while the previous one is still unread, the overrun flag is set and the new word is dropped. Shifting then halts until continuous receive is turned off and back on. Dropping continuous receive also clears the overrun status.

Top module: `sync_slave_rx`

## Requirements
- R1: No word is received unless port enable and synchronous select are both 1 and clock-source select is 0 (0 = clock taken from the remote master).
- R2: The single-receive enable has no effect: with continuous receive at 0, no word is received whatever its value.
- R3: In 8-bit mode (nine-bit enable 0), the data line is sampled at each falling edge of the remote clock. The first sampled bit lands in rx_data bit 0 and the eighth in bit 7.
- R4: In 9-bit mode (nine-bit enable 1), the first eight sampled bits form rx_data and the ninth sampled bit appears on rx_bit9.
- R5: rx_done_flag rises when a word lands in the holding register, and rx_irq equals rx_done_flag AND rx_int_en.
- R6: A one-cycle pulse on rd_strobe clears rx_done_flag.
- R7: A word that completes while rx_done_flag is 1 (and no read is strobed that cycle) sets overrun_flag and leaves rx_data unchanged. No further word is taken until cont_rx_en goes to 0, which also clears overrun_flag.
- R8: Port enable at 0 clears rx_done_flag and overrun_flag and discards any partly shifted word.
- R9: wake_req is a single-cycle pulse, raised in the cycle a word lands when rx_int_en is 1.
- R10: In 8-bit mode, rx_bit9 is 0 after a word lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register domain |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_sclk | input | 1 | Shift clock from the remote master, idle high |
| ext_sdata | input | 1 | Serial data from the remote master |
| port_en | input | 1 | Port enable |
| sync_mode | input | 1 | 1 selects synchronous operation |
| clk_master | input | 1 | 1 = local clock source (master), 0 = slave |
| nine_bit_en | input | 1 | 1 selects 9-bit words |
| cont_rx_en | input | 1 | Continuous-receive enable |
| single_rx_en | input | 1 | Single-receive enable, ignored in slave mode |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rx_data | output | 8 | Holding register, low eight bits of the last word |
| rx_bit9 | output | 1 | Ninth bit of the last word |
| rx_done_flag | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt level |
| overrun_flag | output | 1 | Overrun status |
| wake_req | output | 1 | One-cycle wake request on word arrival |

## Verification
A falling edge on the remote clock takes two synchroniser flops and one edge-detect flop to reach the logic. The holding register, rx_done_flag and wake_req therefore update at the third system clock edge after the falling edge of the final bit. rx_irq follows in the same cycle. Each remote clock phase lasts four system cycles, and the bench waits six more cycles after the final rising edge before it samples any flag or data. All sampling and driving happen on the falling system clock edge. A scoreboard monitor pairs each rise of rx_done_flag with the next expected word. This catches both missing words and words that should have been dropped.

// File: rtl/sync_slave_rx_pkg.sv
// Shared constants for the synchronous slave receiver.
// Assumes words are at most one bit wider than the data byte.
package sync_slave_rx_pkg;
    localparam int DATA_BITS = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int WORD_BITS = DATA_BITS + 1;
    localparam int CNT_BITS = $clog2(WORD_BITS);
    typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous lines.
// Assumes each line is a level that stays stable for many system clocks.
module rx_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Stage g captures the previous stage (or the raw input).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe[g] <= RST_VAL;
                else if (g == 0)
                    pipe[g] <= async_in;
                else
                    pipe[g] <= pipe[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
// Detects falling edges of the synchronised remote clock and places each
// sampled bit at its index (LSB first). word_done pulses on the final bit,
// with the complete word presented on word_out in that same cycle.
// Assumes run stays low whenever reception is not allowed.
module rx_shifter
    import sync_slave_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  sdata_s,
    input  logic  run,
    input  logic  nine_bit,
    output logic  word_done,
    output word_t word_out
);
    logic                sclk_d;
    logic [CNT_BITS-1:0] cnt;
    word_t               sh;
    logic                fall;
    logic [CNT_BITS-1:0] last_idx;

    assign fall     = sclk_d & ~sclk_s;
    assign last_idx = nine_bit ? CNT_BITS'(DATA_BITS) : CNT_BITS'(DATA_BITS - 1);
    assign word_done = run & fall & (cnt == last_idx);

    // Present the word with the bit being sampled now merged in.
    always_comb begin
        word_out = sh;
        word_out[cnt] = sdata_s;
    end

    // Edge history, bit placement and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cnt    <= '0;
            sh     <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (!run) begin
                cnt <= '0;
            end else if (fall) begin
                sh[cnt] <= sdata_s;
                cnt     <= (cnt == last_idx) ? '0 : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_holding.sv
// Holding register with the receive-complete, overrun and wake logic.
// A word is accepted when the flag is clear or a read coincides with it.
// Otherwise the word is dropped and overrun is recorded.
module rx_holding
    import sync_slave_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_done,
    input  word_t                word_in,
    input  logic                 nine_bit,
    input  logic                 int_en,
    input  logic                 rd_strobe,
    input  logic                 port_en,
    input  logic                 cont_en,
    output logic [DATA_BITS-1:0] data,
    output logic                 bit9,
    output logic                 flag,
    output logic                 ovr,
    output logic                 wake
);
    logic land;
    logic ovr_evt;

    assign land    = word_done & (~flag | rd_strobe);
    assign ovr_evt = word_done & flag & ~rd_strobe;

    // Update the holding register, the flags and the wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            bit9 <= 1'b0;
            flag <= 1'b0;
            ovr  <= 1'b0;
            wake <= 1'b0;
        end else if (!port_en) begin
            flag <= 1'b0;
            ovr  <= 1'b0;
            wake <= 1'b0;
        end else begin
            wake <= land & int_en;
            if (land) begin
                data <= word_in[DATA_BITS-1:0];
                bit9 <= nine_bit & word_in[DATA_BITS];
                flag <= 1'b1;
            end else if (rd_strobe) begin
                flag <= 1'b0;
            end
            if (ovr_evt)
                ovr <= 1'b1;
            else if (!cont_en)
                ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_slave_rx.sv
// Top level of the synchronous slave receiver: synchroniser, shifter and
// holding stage. Reception runs only in synchronous slave mode with
// continuous receive on. Any overrun halts it until continuous receive
// is cycled off and on again.
module sync_slave_rx
    import sync_slave_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_sclk,
    input  logic                 ext_sdata,
    input  logic                 port_en,
    input  logic                 sync_mode,
    input  logic                 clk_master,
    input  logic                 nine_bit_en,
    input  logic                 cont_rx_en,
    input  logic                 single_rx_en,
    input  logic                 rx_int_en,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_bit9,
    output logic                 rx_done_flag,
    output logic                 rx_irq,
    output logic                 overrun_flag,
    output logic                 wake_req
);
    logic [1:0] lines_s;
    logic       run;
    logic       word_done;
    word_t      word;

    rx_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({ext_sdata, ext_sclk}),
        .sync_out(lines_s)
    );

    assign run = port_en & sync_mode & ~clk_master & cont_rx_en & ~overrun_flag;

    rx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s[0]),
        .sdata_s  (lines_s[1]),
        .run      (run),
        .nine_bit (nine_bit_en),
        .word_done(word_done),
        .word_out (word)
    );

    rx_holding u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_done(word_done),
        .word_in  (word),
        .nine_bit (nine_bit_en),
        .int_en   (rx_int_en),
        .rd_strobe(rd_strobe),
        .port_en  (port_en),
        .cont_en  (cont_rx_en),
        .data     (rx_data),
        .bit9     (rx_bit9),
        .flag     (rx_done_flag),
        .ovr      (overrun_flag),
        .wake     (wake_req)
    );

    assign rx_irq = rx_done_flag & rx_int_en;
endmodule

// File: rtl/sync_slave_rx_chk.sv
// Property checker for the synchronous slave receiver, bound to the top.
module sync_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       port_en,
    input logic       sync_mode,
    input logic       clk_master,
    input logic       nine_bit_en,
    input logic       cont_rx_en,
    input logic       single_rx_en,
    input logic       rx_int_en,
    input logic       rd_strobe,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       rx_done_flag,
    input logic       overrun_flag,
    input logic       wake_req,
    input logic       word_done
);
    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n) (!sync_mode || clk_master || !port_en) |-> !word_done); // R1
    AST_SINGLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (single_rx_en && !cont_rx_en) |-> !word_done); // R2
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !word_done |=> $stable(rx_data)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_strobe && !word_done) |=> !rx_done_flag); // R6
    AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n) (word_done && rx_done_flag && !rd_strobe) |=> (overrun_flag && $stable(rx_data))); // R7
    AST_PORT_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !port_en |=> (!rx_done_flag && !overrun_flag)); // R8
    AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) wake_req |-> (rx_done_flag && $past(rx_int_en))); // R9
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wake_req |=> !wake_req); // R9
    AST_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (word_done && !nine_bit_en && (!rx_done_flag || rd_strobe)) |=> !rx_bit9); // R10
endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .sync_mode   (sync_mode),
    .clk_master  (clk_master),
    .nine_bit_en (nine_bit_en),
    .cont_rx_en  (cont_rx_en),
    .single_rx_en(single_rx_en),
    .rx_int_en   (rx_int_en),
    .rd_strobe   (rd_strobe),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .rx_done_flag(rx_done_flag),
    .overrun_flag(overrun_flag),
    .wake_req    (wake_req),
    .word_done   (word_done)
);

// File: tb/sync_slave_rx_tb_top.sv
// Scoreboard bench: the driver queues expected words, and a monitor pops
// one on each rise of the receive-complete flag.
module sync_slave_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_sclk = 1'b1, ext_sdata = 1'b0;
    logic port_en = 1'b0, sync_mode = 1'b0, clk_master = 1'b0, nine_bit_en = 1'b0;
    logic cont_rx_en = 1'b0, single_rx_en = 1'b0, rx_int_en = 1'b0, rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit9, rx_done_flag, rx_irq, overrun_flag, wake_req;

    int total = 0;
    int bad = 0;
    int wake_cnt = 0;
    logic flag_q = 1'b0;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;

    sync_slave_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ext_sclk(ext_sclk), .ext_sdata(ext_sdata),
        .port_en(port_en), .sync_mode(sync_mode), .clk_master(clk_master),
        .nine_bit_en(nine_bit_en), .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en),
        .rx_int_en(rx_int_en), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_done_flag(rx_done_flag), .rx_irq(rx_irq),
        .overrun_flag(overrun_flag), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Shift n bits of w, LSB first; each clock phase lasts 4 system cycles.
    task automatic send(input logic [8:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_sdata = w[i];
            repeat (4) @(negedge clk);
            ext_sclk = 1'b0;
            repeat (4) @(negedge clk);
            ext_sclk = 1'b1;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_word(input logic [8:0] w);
        exp_q.push_back(w);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    // Monitor: each rising receive flag must match the next queued word.
    always @(negedge clk) begin
        if (rst_n && rx_done_flag && !flag_q) begin
            if (exp_q.size() == 0) begin
                chk("R3/R4 unexpected word", {23'd0, rx_bit9, rx_data}, 32'h1ff);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R3/R4/R10 word", {23'd0, rx_bit9, rx_data}, {23'd0, e});
            end
        end
        if (wake_req) wake_cnt++;
        flag_q = rx_done_flag;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset flag", rx_done_flag, 0);
        chk("R7 reset overrun", overrun_flag, 0);
        chk("R9 reset wake", wake_req, 0);
        chk("R3 reset data", rx_data, 0);

        // R1: wrong mode selections receive nothing.
        port_en = 1'b1; cont_rx_en = 1'b1; sync_mode = 1'b0;
        send(9'h0c3, 8);
        chk("R1 async mode", rx_done_flag, 0);
        sync_mode = 1'b1; clk_master = 1'b1;
        send(9'h0c3, 8);
        chk("R1 master clock", rx_done_flag, 0);
        clk_master = 1'b0;

        // R2: the single-receive enable alone starts nothing.
        cont_rx_en = 1'b0; single_rx_en = 1'b1;
        send(9'h0c3, 8);
        chk("R2 single enable", rx_done_flag, 0);
        single_rx_en = 1'b0; cont_rx_en = 1'b1;

        // R3 and R5: 8-bit word, interrupt disabled.
        expect_word(9'h0a5);
        send(9'h0a5, 8);
        chk("R5 flag set", rx_done_flag, 1);
        chk("R5 irq masked", rx_irq, 0);
        chk("R9 no wake when masked", wake_cnt, 0);
        do_read();
        chk("R6 read clears flag", rx_done_flag, 0);

        // R4: 9-bit word.
        nine_bit_en = 1'b1;
        expect_word(9'h13c);
        send(9'h13c, 9);
        chk("R4 ninth bit", rx_bit9, 1);
        do_read();

        // R10: back to 8-bit mode, ninth bit reads zero.
        nine_bit_en = 1'b0;
        expect_word(9'h05a);
        send(9'h15a, 8);
        chk("R10 ninth bit zero", rx_bit9, 0);
        do_read();

        // R5 and R9: interrupt enabled.
        rx_int_en = 1'b1;
        expect_word(9'h0e1);
        send(9'h0e1, 8);
        chk("R5 irq raised", rx_irq, 1);
        chk("R9 one wake pulse", wake_cnt, 1);

        // R7: unread word followed by another one.
        send(9'h0ff, 8);
        chk("R7 overrun set", overrun_flag, 1);
        chk("R7 data kept", rx_data, 8'he1);
        do_read();
        send(9'h033, 8);
        chk("R7 halted flag", rx_done_flag, 0);
        chk("R7 halted data", rx_data, 8'he1);
        @(negedge clk) cont_rx_en = 1'b0;
        @(negedge clk);
        chk("R7 overrun cleared", overrun_flag, 0);
        cont_rx_en = 1'b1;
        expect_word(9'h066);
        send(9'h066, 8);
        chk("R7 resumed", rx_data, 8'h66);

        // R8: port disable clears flags and drops a partial word.
        send(9'h00f, 4);
        @(negedge clk) port_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 flag cleared", rx_done_flag, 0);
        chk("R8 overrun cleared", overrun_flag, 0);
        port_en = 1'b1;
        expect_word(9'h081);
        send(9'h081, 8);
        chk("R8 fresh word", rx_data, 8'h81);

        chk("R3 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule